// File: doc/BRIEF.md
# Multi-Mode Response Compactor for Self-Test

This block reduces a long single-bit response stream, taken from a circuit under test one bit per strobe, to one signature word. It then compares that word with a golden signature captured at the start of the run and reports pass or fail. A mode select picks one of three compaction methods: the number of ones, the number of changes between consecutive bits, or the fraction of ones in the stream.

A controller pulses `start` with the mode, the number of response bits to expect and the golden word. It then streams bits with `resp_valid`. One set of counters runs for every mode. For the fraction mode, a sequential restoring divider forms `(ones << FRAC_W) / length` after the last bit. `done` then rises and stays high with `fail` until the next `start`.

Top module: `bist_compactor`

## Requirements
- R1: After reset, `done`=0, `fail`=0 and `signature`=0. A `start` pulse clears all counts, the previous-bit state and both flags, so `done`=0, `fail`=0 and `signature`=0 in the cycle after it.
- R2: With `mode_sel`=2'b00, the signature is the number of accepted bits equal to 1. The code 2'b11 behaves the same way.
- R3: With `mode_sel`=2'b01, the signature is the number of accepted bits that differ from the bit accepted before them. The first bit of a run only seeds the comparison and is never counted, so a run of m bits gives at most m-1.
- R4: With `mode_sel`=2'b10, the signature is floor(ones*2^FRAC_W / test_len). It reaches 2^FRAC_W when every bit is 1. A length of 0 gives 0.
- R5: A bit is accepted only in a cycle where `resp_valid`=1. Strobes arriving after `test_len` bits have been accepted are ignored.
- R6: When the run ends, `fail`=1 exactly when `signature` differs from the golden word latched at `start`.
- R7: In the counting modes, `done` rises two clock edges after the edge that accepts the last bit. In the fraction mode, the divider cycles are added to that delay.
- R8: `done`, `fail` and `signature` hold their values from the end of a run until the next `start`.
- R9: `start` takes priority. A bit strobed in the same cycle as `start` is discarded and does not count toward the new run.
- R10: Reordering a stream leaves the ones count unchanged but can change the transition count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new run; latches mode, length and golden word |
| mode_sel | input | 2 | 00/11 ones, 01 transitions, 10 fraction of ones |
| test_len | input | CNT_W | Number of response bits in the run |
| golden_sig | input | SIG_W | Expected signature |
| resp_bit | input | 1 | Response bit from the circuit under test |
| resp_valid | input | 1 | Strobe qualifying `resp_bit` |
| signature | output | SIG_W | Compacted signature of the selected mode |
| done | output | 1 | Run finished; held until the next start |
| fail | output | 1 | Signature differs from the golden word |

## Verification
Two events can land in the same cycle: a new `start` and a response strobe. `start` must win, and the strobed bit must leave no trace. The bench raises `start` together with `resp_valid` and a 1 bit, then streams an all-zero run. Any nonzero ones count in that run exposes the leaked bit. A second collision is tested as well: a strobe in the cycle right after the last accepted bit, while the block is closing the run. That strobe must not change the signature, the comparison result or the cycle in which `done` rises.

// File: rtl/bist_cmp_pkg.sv
package bist_cmp_pkg;

    typedef enum logic [1:0] {
        MODE_ONES  = 2'b00,
        MODE_TRANS = 2'b01,
        MODE_SYND  = 2'b10,
        MODE_ONES2 = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_DIV,
        ST_CMP,
        ST_DONE
    } state_e;

endpackage

// File: rtl/bist_tally.sv
module bist_tally #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic             bit_in,
    output logic [CNT_W-1:0] ones,
    output logic [CNT_W-1:0] trans,
    output logic [CNT_W-1:0] seen
);

    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic [CNT_W-1:0] trans;
        logic [CNT_W-1:0] seen;
        logic             prev;
        logic             primed;
    } tally_t;

    tally_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d = '0;
        end else if (take) begin
            r_d.seen   = r_q.seen + CNT_W'(1);
            r_d.ones   = r_q.ones + CNT_W'(bit_in);
            if (r_q.primed && (bit_in != r_q.prev)) begin
                r_d.trans = r_q.trans + CNT_W'(1);
            end
            r_d.prev   = bit_in;
            r_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ones  = r_q.ones;
    assign trans = r_q.trans;
    assign seen  = r_q.seen;

endmodule

// File: rtl/bist_frac_div.sv
module bist_frac_div #(
    parameter int NUM_W = 18,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             busy,
    output logic [NUM_W-1:0] quotient
);

    localparam int CW = $clog2(NUM_W);

    typedef struct packed {
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [CW-1:0]    cnt;
        logic             busy;
    } div_t;

    div_t r_d, r_q;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           qbit;

    always_comb begin
        r_d   = r_q;
        trial = {r_q.rem, r_q.quo[NUM_W-1]};
        diff  = trial - {1'b0, divisor};
        qbit  = (trial >= {1'b0, divisor});
        if (load) begin
            r_d.quo  = dividend;
            r_d.rem  = '0;
            r_d.cnt  = '0;
            r_d.busy = 1'b1;
        end else if (r_q.busy) begin
            r_d.rem = qbit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            r_d.quo = {r_q.quo[NUM_W-2:0], qbit};
            r_d.cnt = r_q.cnt + CW'(1);
            if (r_q.cnt == CW'(NUM_W - 1)) begin
                r_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = r_q.busy;
    assign quotient = r_q.quo;

endmodule

// File: rtl/bist_compactor.sv
module bist_compactor
    import bist_cmp_pkg::*;
#(
    parameter  int MAX_LEN = 1000,
    parameter  int FRAC_W  = 8,
    localparam int CNT_W   = $clog2(MAX_LEN + 1),
    localparam int SIG_W   = (CNT_W > FRAC_W + 1) ? CNT_W : FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] test_len,
    input  logic [SIG_W-1:0] golden_sig,
    input  logic             resp_bit,
    input  logic             resp_valid,
    output logic [SIG_W-1:0] signature,
    output logic             done,
    output logic             fail
);

    localparam int DIV_W = CNT_W + FRAC_W;

    typedef struct packed {
        state_e           state;
        mode_e            mode;
        logic [CNT_W-1:0] len;
        logic [SIG_W-1:0] golden;
        logic [SIG_W-1:0] synd;
        logic             done;
        logic             fail;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             take;
    logic             div_load;
    logic             div_busy;
    logic [DIV_W-1:0] div_quo;
    logic [CNT_W-1:0] ones_cnt;
    logic [CNT_W-1:0] trans_cnt;
    logic [CNT_W-1:0] seen_cnt;
    logic [SIG_W-1:0] sig_mux;
    logic [SIG_W-1:0] gold_w;
    logic [CNT_W-1:0] len_w;

    bist_tally #(.CNT_W(CNT_W)) tally_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .take   (take),
        .bit_in (resp_bit),
        .ones   (ones_cnt),
        .trans  (trans_cnt),
        .seen   (seen_cnt)
    );

    bist_frac_div #(.NUM_W(DIV_W), .DEN_W(CNT_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .dividend ({ones_cnt, FRAC_W'(0)}),
        .divisor  (r_q.len),
        .busy     (div_busy),
        .quotient (div_quo)
    );

    always_comb begin
        case (r_q.mode)
            MODE_TRANS: sig_mux = SIG_W'(trans_cnt);
            MODE_SYND:  sig_mux = r_q.synd;
            default:    sig_mux = SIG_W'(ones_cnt);
        endcase
    end

    always_comb begin
        r_d      = r_q;
        take     = 1'b0;
        div_load = 1'b0;
        if (start) begin
            r_d.state  = ST_RUN;
            r_d.mode   = mode_e'(mode_sel);
            r_d.len    = test_len;
            r_d.golden = golden_sig;
            r_d.synd   = '0;
            r_d.done   = 1'b0;
            r_d.fail   = 1'b0;
        end else begin
            case (r_q.state)
                ST_RUN: begin
                    if (seen_cnt == r_q.len) begin
                        if (r_q.mode == MODE_SYND && r_q.len != '0) begin
                            div_load  = 1'b1;
                            r_d.state = ST_DIV;
                        end else begin
                            r_d.state = ST_CMP;
                        end
                    end else begin
                        take = resp_valid;
                    end
                end
                ST_DIV: begin
                    if (!div_busy) begin
                        r_d.synd  = div_quo[SIG_W-1:0];
                        r_d.state = ST_CMP;
                    end
                end
                ST_CMP: begin
                    r_d.fail  = (sig_mux != r_q.golden);
                    r_d.done  = 1'b1;
                    r_d.state = ST_DONE;
                end
                default: r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, mode: MODE_ONES, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign signature = sig_mux;
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign gold_w    = r_q.golden;
    assign len_w     = r_q.len;

endmodule

// File: rtl/bist_compactor_chk.sv
module bist_compactor_chk #(
    parameter int CNT_W = 10,
    parameter int SIG_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic             fail,
    input logic [SIG_W-1:0] signature,
    input logic [SIG_W-1:0] golden,
    input logic [CNT_W-1:0] seen,
    input logic [CNT_W-1:0] len,
    input logic [CNT_W-1:0] trans
);

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !fail));

    assert_first_bit_free_R3: assert property (@(posedge clk) disable iff (rst)
        (seen == '0) |-> (trans == '0));

    assert_trans_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (seen != '0) |-> (trans < seen));

    assert_len_bound_R5: assert property (@(posedge clk) disable iff (rst)
        seen <= len);

    assert_fail_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    assert_pass_matches_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> (signature == golden));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail) && $stable(signature)));

endmodule

bind bist_compactor bist_compactor_chk #(.CNT_W(CNT_W), .SIG_W(SIG_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .fail      (fail),
    .signature (signature),
    .golden    (gold_w),
    .seen      (seen_cnt),
    .len       (len_w),
    .trans     (trans_cnt)
);

// File: tb/bist_compactor_tb.sv
module bist_compactor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 1000;
    localparam int FRAC_W     = 8;
    localparam int CNT_W      = $clog2(MAX_LEN + 1);
    localparam int SIG_W      = (CNT_W > FRAC_W + 1) ? CNT_W : FRAC_W + 1;

    typedef struct packed {
        logic [1:0]  mode;
        logic [5:0]  len;
        logic [31:0] pat;
        logic        bad;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b00, 6'd8,  32'h0000_00B2, 1'b0},
        '{2'b01, 6'd8,  32'h0000_00B2, 1'b0},
        '{2'b10, 6'd8,  32'h0000_00B2, 1'b0},
        '{2'b00, 6'd12, 32'h0000_0FFF, 1'b1},
        '{2'b01, 6'd1,  32'h0000_0001, 1'b0},
        '{2'b10, 6'd3,  32'h0000_0007, 1'b0},
        '{2'b10, 6'd5,  32'h0000_0001, 1'b0},
        '{2'b01, 6'd16, 32'h0000_AAAA, 1'b0},
        '{2'b01, 6'd16, 32'h0000_00FF, 1'b1},
        '{2'b11, 6'd16, 32'h0000_5555, 1'b0},
        '{2'b10, 6'd32, 32'hFFFF_FFFF, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       mode_sel = 2'b00;
    logic [CNT_W-1:0] test_len = '0;
    logic [SIG_W-1:0] golden_sig = '0;
    logic             resp_bit = 1'b0;
    logic             resp_valid = 1'b0;
    logic [SIG_W-1:0] signature;
    logic             done;
    logic             fail;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bist_compactor #(.MAX_LEN(MAX_LEN), .FRAC_W(FRAC_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode_sel   (mode_sel),
        .test_len   (test_len),
        .golden_sig (golden_sig),
        .resp_bit   (resp_bit),
        .resp_valid (resp_valid),
        .signature  (signature),
        .done       (done),
        .fail       (fail)
    );

    function automatic int ref_sig(logic [1:0] m, int len, logic [31:0] p);
        int ones = 0;
        int tr = 0;
        for (int i = 0; i < len; i++) begin
            ones += int'(p[i]);
            if (i > 0 && p[i] != p[i-1]) tr++;
        end
        if (m == 2'b01) return tr;
        if (m == 2'b10) return (len == 0) ? 0 : (ones * (1 << FRAC_W)) / len;
        return ones;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(logic [1:0] m, int len, int gold, bit with_bit);
        @(negedge clk);
        start      = 1'b1;
        mode_sel   = m;
        test_len   = CNT_W'(len);
        golden_sig = SIG_W'(gold);
        resp_valid = with_bit;
        resp_bit   = with_bit;
        @(negedge clk);
        start      = 1'b0;
        resp_valid = 1'b0;
        resp_bit   = 1'b0;
    endtask

    task automatic feed(logic [31:0] p, int len, bit gaps);
        for (int i = 0; i < len; i++) begin
            if (gaps) begin
                resp_valid = 1'b0;
                resp_bit   = 1'b1;
                @(negedge clk);
            end
            resp_valid = 1'b1;
            resp_bit   = p[i];
            @(negedge clk);
        end
        resp_valid = 1'b0;
        resp_bit   = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !fail && signature == '0, "R1 reset state",
              int'({done, fail}) + int'(signature), 0);

        // table walk: R2 R3 R4 R6 R10
        for (int v = 0; v < NV; v++) begin
            exp = ref_sig(VECS[v].mode, int'(VECS[v].len), VECS[v].pat);
            pulse_start(VECS[v].mode, int'(VECS[v].len),
                        VECS[v].bad ? exp + 1 : exp, 1'b0);
            feed(VECS[v].pat, int'(VECS[v].len), 1'b0);
            wait_done();
            check(done, "R7 run completes", int'(done), 1);
            check(int'(signature) == exp, "R2/R3/R4 signature R10",
                  int'(signature), exp);
            check(fail == VECS[v].bad, "R6 compare result",
                  int'(fail), int'(VECS[v].bad));
        end

        // R7 exact latency in a counting mode, then R5 late strobes, R8 hold
        pulse_start(2'b00, 4, 3, 1'b0);
        feed(32'h0000_000B, 4, 1'b0);
        check(!done, "R7 not done one edge after last bit", int'(done), 0);
        resp_valid = 1'b1;
        resp_bit   = 1'b1;
        @(negedge clk);
        check(!done, "R7 not done two edges... wait", int'(done), 0);
        @(negedge clk);
        check(done, "R7 done two edges after last bit", int'(done), 1);
        for (int k = 0; k < 5; k++) @(negedge clk);
        resp_valid = 1'b0;
        check(int'(signature) == 3, "R5 late strobes ignored", int'(signature), 3);
        check(done && !fail, "R8 flags held", int'({done, fail}), 2);

        // R5 valid-low cycles carrying ones are ignored
        pulse_start(2'b00, 6, 2, 1'b0);
        feed(32'h0000_0021, 6, 1'b1);
        wait_done();
        check(int'(signature) == 2, "R5 gaps ignored", int'(signature), 2);

        // R9 start collides with a strobe
        pulse_start(2'b00, 3, 0, 1'b1);
        feed(32'h0, 3, 1'b0);
        wait_done();
        check(int'(signature) == 0 && !fail, "R9 start wins over strobe",
              int'(signature), 0);

        // R1 restart mid-run clears everything
        pulse_start(2'b00, 8, 8, 1'b0);
        feed(32'h0000_0007, 3, 1'b0);
        pulse_start(2'b01, 2, 0, 1'b0);
        check(!done && !fail && signature == '0, "R1 start clears",
              int'(signature), 0);
        feed(32'h0, 2, 1'b0);
        wait_done();
        check(int'(signature) == 0 && !fail, "R1 fresh run after restart",
              int'(signature), 0);

        // R4 zero length in fraction mode
        pulse_start(2'b10, 0, 0, 1'b0);
        wait_done();
        check(done && signature == '0, "R4 zero length", int'(signature), 0);

        // R8 fail held over idle cycles
        pulse_start(2'b00, 2, 0, 1'b0);
        feed(32'h0000_0003, 2, 1'b0);
        wait_done();
        for (int k = 0; k < 10; k++) @(negedge clk);
        check(done && fail, "R8 fail held", int'({done, fail}), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule